// File: doc/BRIEF.md
# Video Pixel Output Port Formatter

This block sits at the end of a video processing pipeline. Each clock it receives one processed pixel: three 10-bit components (A, B, C) with a data-enable, a horizontal sync flag, a vertical sync flag and a field flag. It places the components onto a 30-bit parallel pixel port in one of several packings. In the single-rate packings the same word is shown for the whole clock period. In the double-rate packings the word shown while the clock is high differs from the one shown while it is low.

For 4:2:2 packings, component A is luma. Components B (Cb) and C (Cr) both arrive every pixel, and the block picks one of them, alternating from pixel to pixel. The packing is chosen by a host-written mode field. The block only adopts a new value of that field at the next vertical sync rising edge, so a frame never mixes packings. A shared flag output carries either the field flag or the data-enable, chosen by a configuration bit.

Top module: `pix_out_fmt`

## Requirements
- R1: Mode 0 (single-rate 4:2:2, 20-bit) puts luma A on P[19:10] and the selected chroma on P[9:0], with P[29:20] at zero. Mode 0 is also the mode in force after reset.
- R2: Mode 1 (single-rate 4:2:2, 16-bit) puts the upper 8 bits of A on P[19:12] and the upper 8 bits of the chroma on P[9:2]. All other bits are zero.
- R3: Mode 2 (single-rate 4:4:4, 30-bit) puts A on P[19:10], B on P[9:0] and C on P[29:20].
- R4: Mode 3 (single-rate 4:4:4, 24-bit) uses the same lanes as mode 2 but carries only the upper 8 bits of each component. Bits [1:0] of each 10-bit lane are zero.
- R5: Mode 4 (double-rate 4:2:2, 10-bit) drives the chroma on P[9:0] while the clock is high and luma A on P[9:0] while the clock is low. P[29:10] is zero.
- R6: Mode 5 (double-rate 4:2:2, 8-bit) is mode 4 reduced to the upper 8 bits of each value, placed on P[9:2], with all other bits zero.
- R7: Mode 6 (double-rate 4:4:4, 12-bit) forms the word W = {A[9:2], B[9:2], C[9:2]}. It drives W[23:12] on P[11:0] while the clock is high and W[11:0] while the clock is low, with the rest zero. Mode 7 drives all data bits to zero.
- R8: In 4:2:2 modes the first pixel after each rising edge of data-enable carries Cb (component B). The chroma then alternates Cr, Cb, ... on each further enabled pixel.
- R9: When data-enable is low, all 30 pixel bits are zero in both clock phases. After reset all outputs are zero.
- R10: A change of the mode input takes effect only for pixels accepted on clock edges after the edge at which the vertical sync input is first seen high.
- R11: The pixel data and the HS/VS outputs appear on the first rising clock edge after the input is sampled, so they stay aligned. In single-rate modes both clock phases show the same word.
- R12: The shared flag output carries the data-enable when the select input is 1 and the field flag when it is 0. It has the same one-edge delay as the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; its level also selects the double-rate half |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 3 | Requested packing mode (0 to 7), adopted at vertical sync |
| cfg_fd_de | input | 1 | 1: shared flag output carries data-enable, 0: field flag |
| in_de | input | 1 | Pixel data-enable |
| in_hs | input | 1 | Horizontal sync flag |
| in_vs | input | 1 | Vertical sync flag |
| in_fld | input | 1 | Field flag |
| in_a | input | 10 | Component A (luma or G) |
| in_b | input | 10 | Component B (Cb or second colour) |
| in_c | input | 10 | Component C (Cr or third colour) |
| out_pix | output | 30 | Parallel pixel port |
| out_hs | output | 1 | Horizontal sync output |
| out_vs | output | 1 | Vertical sync output |
| out_fd | output | 1 | Shared field / data-enable output |

## Verification
An input applied before rising edge k appears after that same edge. The high-phase word and the flags are valid from edge k until the following falling edge, and the low-phase word is valid from that falling edge until edge k+1. The driver pushes one expected entry per clock, computed from its own model of mode adoption and chroma order. The monitor pops each entry one nanosecond after the rising edge to compare the high word and flags, and one nanosecond after the next falling edge to compare the low word, so every sample falls inside a stable half-period.

// File: rtl/pof_pkg.sv
package pof_pkg;
  typedef enum logic [2:0] {
    PM_S422_20 = 3'd0,
    PM_S422_16 = 3'd1,
    PM_S444_30 = 3'd2,
    PM_S444_24 = 3'd3,
    PM_D422_10 = 3'd4,
    PM_D422_8  = 3'd5,
    PM_D444_12 = 3'd6,
    PM_OFF     = 3'd7
  } pof_mode_t;
endpackage

// File: rtl/pof_mode_reg.sv
module pof_mode_reg
  import pof_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vs,
  input  pof_mode_t cfg_mode,
  output pof_mode_t mode
);
  logic      vs_prev;
  pof_mode_t mode_q, mode_n;
  logic      vs_rise;

  assign vs_rise = vs & ~vs_prev;

  always_comb begin
    mode_n = mode_q;
    if (vs_rise) mode_n = cfg_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_prev <= 1'b0;
      mode_q  <= PM_S422_20;
    end else begin
      vs_prev <= vs;
      mode_q  <= mode_n;
    end
  end

  assign mode = mode_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vs && !vs_prev) |=> $stable(mode_q));
endmodule

// File: rtl/pof_chroma_seq.sv
module pof_chroma_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic de,
  output logic sel_cr
);
  logic de_prev, cr_next, cr_next_n;

  always_comb begin
    sel_cr    = de_prev ? cr_next : 1'b0;
    cr_next_n = de ? ~sel_cr : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_prev <= 1'b0;
      cr_next <= 1'b0;
    end else begin
      de_prev <= de;
      cr_next <= cr_next_n;
    end
  end

  // R8
  cb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> !sel_cr);
  // R8
  chroma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (sel_cr != $past(sel_cr)));
endmodule

// File: rtl/pof_lane_pack.sv
module pof_lane_pack
  import pof_pkg::*;
#(
  parameter int CW = 10
) (
  input  pof_mode_t         mode,
  input  logic              de,
  input  logic              sel_cr,
  input  logic [CW-1:0]     a,
  input  logic [CW-1:0]     b,
  input  logic [CW-1:0]     c,
  output logic [3*CW-1:0]   word_hi,
  output logic [3*CW-1:0]   word_lo
);
  localparam int NW = CW - 2;
  localparam int PW = 3 * CW;
  localparam int HW = 3 * NW / 2;

  logic [CW-1:0]   chroma, na, nb, nc, nch;
  logic [3*NW-1:0] w3;

  always_comb begin
    chroma = sel_cr ? c : b;
    na     = {a[CW-1:2], 2'b00};
    nb     = {b[CW-1:2], 2'b00};
    nc     = {c[CW-1:2], 2'b00};
    nch    = {chroma[CW-1:2], 2'b00};
    w3     = {a[CW-1:2], b[CW-1:2], c[CW-1:2]};
    word_hi = '0;
    word_lo = '0;
    if (de) begin
      unique case (mode)
        PM_S422_20: word_hi = {{CW{1'b0}}, a, chroma};
        PM_S422_16: word_hi = {{CW{1'b0}}, na, nch};
        PM_S444_30: word_hi = {c, a, b};
        PM_S444_24: word_hi = {nc, na, nb};
        PM_D422_10: begin
          word_hi = {{(PW-CW){1'b0}}, chroma};
          word_lo = {{(PW-CW){1'b0}}, a};
        end
        PM_D422_8: begin
          word_hi = {{(PW-CW){1'b0}}, nch};
          word_lo = {{(PW-CW){1'b0}}, na};
        end
        PM_D444_12: begin
          word_hi = {{(PW-HW){1'b0}}, w3[3*NW-1:HW]};
          word_lo = {{(PW-HW){1'b0}}, w3[HW-1:0]};
        end
        default: begin
          word_hi = '0;
          word_lo = '0;
        end
      endcase
      if (mode < PM_D422_10) word_lo = word_hi;
    end
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int CW = 10,
  localparam int PW = 3 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_mode,
  input  logic          cfg_fd_de,
  input  logic          in_de,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic          in_fld,
  input  logic [CW-1:0] in_a,
  input  logic [CW-1:0] in_b,
  input  logic [CW-1:0] in_c,
  output logic [PW-1:0] out_pix,
  output logic          out_hs,
  output logic          out_vs,
  output logic          out_fd
);
  logic      rs_meta, rs_n;
  pof_mode_t mode_q;
  logic      sel_cr;
  logic [PW-1:0] hi_n, lo_n, rise_q, fall_q;
  logic      hs_q, vs_q, fd_q, fd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  pof_mode_reg u_mode (
    .clk(clk), .rst_n(rs_n), .vs(in_vs),
    .cfg_mode(pof_mode_t'(cfg_mode)), .mode(mode_q)
  );

  pof_chroma_seq u_chr (
    .clk(clk), .rst_n(rs_n), .de(in_de), .sel_cr(sel_cr)
  );

  pof_lane_pack #(.CW(CW)) u_pack (
    .mode(mode_q), .de(in_de), .sel_cr(sel_cr),
    .a(in_a), .b(in_b), .c(in_c),
    .word_hi(hi_n), .word_lo(lo_n)
  );

  assign fd_n = cfg_fd_de ? in_de : in_fld;

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      rise_q <= '0;
      fall_q <= '0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      fd_q   <= 1'b0;
    end else begin
      rise_q <= hi_n;
      fall_q <= lo_n;
      hs_q   <= in_hs;
      vs_q   <= in_vs;
      fd_q   <= fd_n;
    end
  end

  assign out_pix = clk ? rise_q : fall_q;
  assign out_hs  = hs_q;
  assign out_vs  = vs_q;
  assign out_fd  = fd_q;

  // R9
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rs_n)
    !in_de |=> (rise_q == '0 && fall_q == '0));
  // R11
  sdr_same_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (in_de && mode_q < PM_D422_10) |=> (rise_q == fall_q));
  // R12
  fd_de_chk: assert property (@(posedge clk) disable iff (!rs_n)
    cfg_fd_de |=> (out_fd == $past(in_de)));
endmodule

// File: tb/sim_pix_out_fmt.sv
`timescale 1ns/100ps
module sim_pix_out_fmt;
  localparam int CW = 10;
  localparam int PW = 3 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_fd_de = 1'b0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0, in_fld = 1'b0;
  logic [CW-1:0] in_a = '0, in_b = '0, in_c = '0;
  wire  [PW-1:0] out_pix;
  wire  out_hs, out_vs, out_fd;

  always #2.5 clk = ~clk;

  pix_out_fmt #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fd_de(cfg_fd_de),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_fld(in_fld),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs), .out_fd(out_fd)
  );

  typedef struct {
    logic [PW-1:0] hi;
    logic [PW-1:0] lo;
    logic hs, vs, fd;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  string extra = "";

  // bench model state
  logic [2:0] m_mode = 3'd0;
  logic m_vsp = 1'b0, m_dep = 1'b0, m_crn = 1'b0;

  function automatic logic [CW-1:0] nar(input logic [CW-1:0] x);
    return {x[CW-1:2], 2'b00};
  endfunction

  task automatic drive(input logic de, input logic hs, input logic vs,
                       input logic fld, input logic [CW-1:0] a,
                       input logic [CW-1:0] b, input logic [CW-1:0] c);
    exp_t e;
    logic cr;
    logic [CW-1:0] ch;
    logic [23:0] w;
    @(negedge clk); #2;
    in_de = de; in_hs = hs; in_vs = vs; in_fld = fld;
    in_a = a; in_b = b; in_c = c;
    cr = de && m_dep ? m_crn : 1'b0;
    ch = cr ? c : b;
    w  = {a[9:2], b[9:2], c[9:2]};
    e.hi = '0; e.lo = '0;
    e.hs = hs; e.vs = vs; e.fd = cfg_fd_de ? de : fld;
    e.tag = $sformatf("R%0d%s", int'(m_mode) + 1, extra);
    if (m_mode == 3'd7) e.tag = {"R7", extra};
    if (de) begin
      case (m_mode)
        3'd0: e.hi = {10'd0, a, ch};          // R1 with R8 chroma order
        3'd1: e.hi = {10'd0, nar(a), nar(ch)}; // R2
        3'd2: e.hi = {c, a, b};                // R3
        3'd3: e.hi = {nar(c), nar(a), nar(b)}; // R4
        3'd4: begin e.hi = {20'd0, ch}; e.lo = {20'd0, a}; end           // R5
        3'd5: begin e.hi = {20'd0, nar(ch)}; e.lo = {20'd0, nar(a)}; end // R6
        3'd6: begin e.hi = {18'd0, w[23:12]}; e.lo = {18'd0, w[11:0]}; end // R7
        default: ;
      endcase
      if (m_mode < 3'd4) e.lo = e.hi;          // R11
      if (m_mode == 3'd0 || m_mode == 3'd1 || m_mode == 3'd4 || m_mode == 3'd5)
        e.tag = {e.tag, "/R8"};
    end else begin
      e.tag = {"R9", extra};
    end
    q.push_back(e);
    m_crn = de ? ~cr : 1'b0;
    m_dep = de;
    if (vs && !m_vsp) m_mode = cfg_mode;       // R10
    m_vsp = vs;
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (out_pix !== e.hi) begin
          fails++;
          $display("FAIL %s high phase: got %h exp %h", e.tag, out_pix, e.hi);
        end
        if (out_hs !== e.hs || out_vs !== e.vs) begin
          fails++;
          $display("FAIL R11 sync: got hs=%b vs=%b exp hs=%b vs=%b",
                   out_hs, out_vs, e.hs, e.vs);
        end
        if (out_fd !== e.fd) begin
          fails++;
          $display("FAIL R12 shared flag: got %b exp %b", out_fd, e.fd);
        end
        @(negedge clk); #1;
        if (out_pix !== e.lo) begin
          fails++;
          $display("FAIL %s low phase: got %h exp %h", e.tag, out_pix, e.lo);
        end
      end
    end
  end

  task automatic idle(input int n, input logic hs);
    for (int i = 0; i < n; i++) drive(1'b0, hs, 1'b0, 1'b1, 10'h3ff, 10'h155, 10'h2aa);
  endtask

  task automatic line(input int n, input int seed);
    for (int i = 0; i < n; i++)
      drive(1'b1, 1'b0, 1'b0, 1'b0, 10'(seed + 37 * i), 10'(seed * 3 + 91 * i + 5),
            10'(seed * 7 + 53 * i + 11));
  endtask

  task automatic vsync(input logic [2:0] m);
    @(negedge clk); #2; cfg_mode = m;
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
    idle(2, 1'b1);
  endtask

  function automatic void show_summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1;
    checks++;
    // R9 reset state
    if (out_pix !== '0 || out_hs !== 1'b0 || out_vs !== 1'b0 || out_fd !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset: got pix=%h hs=%b vs=%b fd=%b exp all zero",
               out_pix, out_hs, out_vs, out_fd);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 default mode after reset, no vsync yet
    line(4, 17);
    idle(2, 1'b1);
    for (int m = 0; m < 8; m++) begin
      vsync(3'(m));
      line(6, 40 + 13 * m);
      idle(2, 1'b1);
      line(5, 200 + m);   // R8 chroma restarts at Cb
      idle(1, 1'b0);
    end
    // R10: mode request without vsync is not adopted
    vsync(3'd2);
    @(negedge clk); #2; cfg_mode = 3'd6;
    extra = "/R10";
    line(4, 300);
    idle(1, 1'b0);
    vsync(3'd6);
    line(4, 310);
    idle(1, 1'b0);
    extra = "";
    // R12: shared flag carries data-enable
    vsync(3'd0);
    @(negedge clk); #2; cfg_fd_de = 1'b1;
    idle(2, 1'b0);
    line(3, 400);
    idle(2, 1'b1);
    line(2, 410);
    @(negedge clk); #2; cfg_fd_de = 1'b0;
    idle(2, 1'b0);
    line(2, 420);
    idle(3, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending entries: got %0d exp 0", q.size());
    end
    done = 1;
    show_summary();
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      show_summary();
      $finish;
    end
  end
endmodule